// File: doc/BRIEF.md
# DMA Translation Fault Recorder

This block captures DMA address-translation faults into a small circular set of fixed-size fault records. It also keeps a status word that summarises them. Each fault arrives as a one-cycle strobe with four fields: the 64-bit faulting address, the 16-bit requester identifier, an 8-bit reason code, and a flag that tells a read from a write. The hardware writes the fault into the slot after the one it last filled. Software reads the records over a simple 32-bit register port and retires each record by writing a one to its valid bit.

Two read-only capability words tell software where the record window starts and how many records it holds. When a new fault would land on a record that is still occupied, the fault is discarded and a sticky overflow flag is raised. While that flag stays up, every further fault is discarded. Each recorded fault can also notify the host with a single write request, built from programmable data and address registers. A mask bit can hold this notification back; a pending flag remembers it until the mask is lifted.

Top module: `dma_fault_ring`

## Requirements
- R1: After reset, every register reads as follows. The status word reads 0. The event control word reads 0x8000_0000 (masked, nothing pending). The data, address and upper address registers read 0. No record is valid and no event is issued.
- R2: The capability word at 0x08 carries the low 8 bits of the 10-bit window field in bits 31:24. The word at 0x0C carries the field's top 2 bits in bits 1:0 and the record count minus one in bits 15:8. All other bits of both words read 0. The window's byte offset is 16 times the field.
- R3: A record occupies 16 bytes. The word at +0 holds address bits 31:0 and the word at +4 holds address bits 63:32. The word at +8 holds the requester ID in bits 15:0. The word at +12 holds the reason in bits 7:0, the type in bit 30 (1 = read) and the valid bit in bit 31.
- R4: Recorded faults fill slots in circular order 0, 1, …, N-1, then return to 0. A fault is written into the slot after the last one recorded.
- R5: Writing 1 to bit 31 of a record's +12 word clears that record's valid bit. Writing 0 there has no effect, and writes to the other record words are ignored.
- R6: Status bit 1 reads 1 while any record is valid. Status bits 15:8 give the oldest valid record, found by searching circularly from the next write slot. When no record is valid, they give the next write slot.
- R7: A fault whose target slot is still valid is discarded: that record keeps its content and status bit 0 (overflow) is set.
- R8: While the overflow flag is set, no fault is recorded. Writing 1 to status bit 0 clears the flag.
- R9: When software retires a slot in the same cycle that a fault targets that slot, the fault is recorded and no overflow is raised.
- R10: With the mask clear, a recorded fault produces a one-cycle event in the cycle after it is recorded. The event carries the data register as its data and {upper address, address} as its address.
- R11: With the mask set (control bit 31), a recorded fault issues no event and sets control bit 30 instead. Clearing the mask while bit 30 is set issues one event and clears bit 30.
- R12: The data, address and upper address registers read back what was written. Of the control word, only bit 31 is writable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flt_valid | input | 1 | Fault report strobe |
| flt_addr | input | 64 | Faulting DMA address |
| flt_rid | input | 16 | Requester identifier |
| flt_reason | input | 8 | Fault reason code |
| flt_is_read | input | 1 | 1 = read access faulted |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Register byte address |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data (combinational) |
| evt_valid | output | 1 | Event write request, one cycle |
| evt_addr | output | 64 | Event write address |
| evt_data | output | 32 | Event write data |

## Verification
A fault report and a software retire can land in the same cycle on the same slot, and that is when recording and retiring collide. The bench drives both strobes on one clock edge while the targeted slot is still occupied. It then reads the slot back and expects the new fault's address in it, with the overflow bit still clear. A second collision, lifting the mask while an event is pending, is judged by counting the event pulses seen at the output.

// File: rtl/fr_pkg.sv
package fr_pkg;
  // Register offsets that software decodes
  localparam int OFS_CAP_LO = 'h08;
  localparam int OFS_CAP_HI = 'h0C;
  localparam int OFS_STAT   = 'h34;
  localparam int OFS_CTRL   = 'h38;
  localparam int OFS_DATA   = 'h3C;
  localparam int OFS_ADDR   = 'h40;
  localparam int OFS_UADDR  = 'h44;

  typedef struct packed {
    logic [63:0] addr;
    logic [15:0] rid;
    logic [7:0]  reason;
    logic        is_rd;
  } fr_rec_t;
endpackage

// File: rtl/fr_record_bank.sv
module fr_record_bank
  import fr_pkg::*;
#(
  parameter int NREC  = 4,
  parameter int IDX_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  fr_rec_t          wr_rec,
  input  logic [NREC-1:0]  clr_vec,
  output logic [NREC-1:0]  valid_vec,
  input  logic [IDX_W-1:0] rd_idx,
  input  logic [1:0]       rd_word,
  output logic [31:0]      rd_data
);
  fr_rec_t recs [NREC];

  for (genvar g = 0; g < NREC; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        valid_vec[g] <= 1'b0;
        recs[g]      <= '0;
      end else begin
        if (clr_vec[g]) valid_vec[g] <= 1'b0;
        if (wr_en && wr_idx == IDX_W'(g)) begin
          valid_vec[g] <= 1'b1;
          recs[g]      <= wr_rec;
        end
      end
    end
  end

  always_comb begin
    fr_rec_t r;
    r = (int'(rd_idx) < NREC) ? recs[rd_idx] : '0;
    unique case (rd_word)
      2'd0: rd_data = r.addr[31:0];
      2'd1: rd_data = r.addr[63:32];
      2'd2: rd_data = {16'h0, r.rid};
      default: rd_data = {valid_vec[rd_idx], r.is_rd, 22'h0, r.reason};
    endcase
  end

  // R7: the bank is only ever written into a slot that is free this cycle
  a_r7_write_free_slot: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (!valid_vec[wr_idx] || clr_vec[wr_idx]));
  // R4: a written slot holds a valid record afterwards
  a_r4_written_valid: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> valid_vec[$past(wr_idx)]);
endmodule

// File: rtl/fr_event_unit.sv
module fr_event_unit (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ctrl_we,
  input  logic        ctrl_wmask,
  input  logic        data_we,
  input  logic        addr_we,
  input  logic        uaddr_we,
  input  logic [31:0] wdata,
  input  logic        rec_we,
  output logic        mask,
  output logic        ip,
  output logic [31:0] data_r,
  output logic [31:0] addr_r,
  output logic [31:0] uaddr_r,
  output logic        evt_valid,
  output logic [63:0] evt_addr,
  output logic [31:0] evt_data
);
  logic mask_n, fire;

  assign mask_n = ctrl_we ? ctrl_wmask : mask;
  assign fire   = !mask_n && (rec_we || ip);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask      <= 1'b1;
      ip        <= 1'b0;
      data_r    <= '0;
      addr_r    <= '0;
      uaddr_r   <= '0;
      evt_valid <= 1'b0;
      evt_addr  <= '0;
      evt_data  <= '0;
    end else begin
      mask      <= mask_n;
      ip        <= mask_n && (ip || rec_we);
      evt_valid <= fire;
      if (fire) begin
        evt_data <= data_r;
        evt_addr <= {uaddr_r, addr_r};
      end
      if (data_we)  data_r  <= wdata;
      if (addr_we)  addr_r  <= wdata;
      if (uaddr_we) uaddr_r <= wdata;
    end
  end

  // R11: a pending event only exists while the mask holds it back
  a_r11_ip_only_masked: assert property (@(posedge clk) disable iff (!rst_n)
    ip |-> mask);
  // R11: lifting the mask with an event pending issues it
  a_r11_unmask_sends: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(mask) && $past(ip)) |-> evt_valid);
  // R10: an unmasked recording issues an event next cycle
  a_r10_unmasked_event: assert property (@(posedge clk) disable iff (!rst_n)
    (rec_we && !mask && !ctrl_we) |=> evt_valid);
endmodule

// File: rtl/dma_fault_ring.sv
module dma_fault_ring
  import fr_pkg::*;
#(
  parameter int NREC       = 4,
  parameter int RING_FIELD = 'h104,
  parameter int ADDR_W     = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flt_valid,
  input  logic [63:0]       flt_addr,
  input  logic [15:0]       flt_rid,
  input  logic [7:0]        flt_reason,
  input  logic              flt_is_read,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              evt_valid,
  output logic [63:0]       evt_addr,
  output logic [31:0]       evt_data
);
  localparam int IDX_W = (NREC > 1) ? $clog2(NREC) : 1;
  localparam logic [9:0]        RING_F   = 10'(RING_FIELD);
  localparam logic [ADDR_W-1:0] RING_LO  = ADDR_W'(RING_FIELD * 16);
  localparam logic [ADDR_W-1:0] RING_HI  = ADDR_W'(RING_FIELD * 16 + NREC * 16);

  function automatic logic [IDX_W-1:0] next_idx(logic [IDX_W-1:0] i);
    return (int'(i) == NREC - 1) ? '0 : i + 1'b1;
  endfunction

  // Oldest valid record, searched circularly from the next write slot
  function automatic logic [IDX_W-1:0] oldest(logic [NREC-1:0] v, logic [IDX_W-1:0] start);
    logic [IDX_W-1:0] res;
    logic found;
    res = start;
    found = 1'b0;
    for (int k = 0; k < NREC; k++) begin
      int j;
      j = int'(start) + k;
      if (j >= NREC) j = j - NREC;
      if (!found && v[j]) begin
        res   = IDX_W'(j);
        found = 1'b1;
      end
    end
    return res;
  endfunction

  logic [IDX_W-1:0]  wptr;
  logic              ovf;
  logic [NREC-1:0]   valid_vec, clr_vec, eff_valid;
  logic              slot_full, rec_we, drop;
  logic              in_ring, stat_w1c;
  logic [ADDR_W-1:0] ring_off;
  logic [IDX_W-1:0]  slot;
  logic [31:0]       bank_rd;
  logic              mask, ip;
  logic [31:0]       data_r, addr_r, uaddr_r;
  fr_rec_t           new_rec;

  assign in_ring  = (bus_addr >= RING_LO) && (bus_addr < RING_HI);
  assign ring_off = bus_addr - RING_LO;
  assign slot     = ring_off[IDX_W+3:4];

  for (genvar g = 0; g < NREC; g++) begin : g_clr
    assign clr_vec[g] = bus_wr && in_ring && slot == IDX_W'(g) &&
                        ring_off[3:2] == 2'd3 && bus_wdata[31];
  end

  assign eff_valid = valid_vec & ~clr_vec;
  assign slot_full = eff_valid[wptr];
  assign rec_we    = flt_valid && !ovf && !slot_full;
  assign drop      = flt_valid && !ovf && slot_full;
  assign stat_w1c  = bus_wr && bus_addr == ADDR_W'(OFS_STAT) && bus_wdata[0];
  assign new_rec   = '{addr: flt_addr, rid: flt_rid, reason: flt_reason, is_rd: flt_is_read};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wptr <= '0;
      ovf  <= 1'b0;
    end else begin
      if (rec_we) wptr <= next_idx(wptr);
      ovf <= (ovf && !stat_w1c) || drop;
    end
  end

  fr_record_bank #(.NREC(NREC), .IDX_W(IDX_W)) u_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(rec_we), .wr_idx(wptr), .wr_rec(new_rec),
    .clr_vec(clr_vec), .valid_vec(valid_vec), .rd_idx(slot),
    .rd_word(ring_off[3:2]), .rd_data(bank_rd)
  );

  fr_event_unit u_evt (
    .clk(clk), .rst_n(rst_n),
    .ctrl_we(bus_wr && bus_addr == ADDR_W'(OFS_CTRL)), .ctrl_wmask(bus_wdata[31]),
    .data_we(bus_wr && bus_addr == ADDR_W'(OFS_DATA)),
    .addr_we(bus_wr && bus_addr == ADDR_W'(OFS_ADDR)),
    .uaddr_we(bus_wr && bus_addr == ADDR_W'(OFS_UADDR)),
    .wdata(bus_wdata), .rec_we(rec_we), .mask(mask), .ip(ip),
    .data_r(data_r), .addr_r(addr_r), .uaddr_r(uaddr_r),
    .evt_valid(evt_valid), .evt_addr(evt_addr), .evt_data(evt_data)
  );

  always_comb begin
    bus_rdata = '0;
    if (in_ring) bus_rdata = bank_rd;
    else if (bus_addr == ADDR_W'(OFS_CAP_LO)) bus_rdata = {RING_F[7:0], 24'h0};
    else if (bus_addr == ADDR_W'(OFS_CAP_HI)) bus_rdata = {16'h0, 8'(NREC - 1), 6'h0, RING_F[9:8]};
    else if (bus_addr == ADDR_W'(OFS_STAT))
      bus_rdata = {16'h0, 8'(oldest(valid_vec, wptr)), 6'h0, |valid_vec, ovf};
    else if (bus_addr == ADDR_W'(OFS_CTRL))  bus_rdata = {mask, ip, 30'h0};
    else if (bus_addr == ADDR_W'(OFS_DATA))  bus_rdata = data_r;
    else if (bus_addr == ADDR_W'(OFS_ADDR))  bus_rdata = addr_r;
    else if (bus_addr == ADDR_W'(OFS_UADDR)) bus_rdata = uaddr_r;
  end

  // R8: nothing is recorded while overflow stands
  a_r8_ovf_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |-> !rec_we);
  // R7: a fault hitting an occupied slot raises overflow
  a_r7_full_sets_ovf: assert property (@(posedge clk) disable iff (!rst_n)
    (flt_valid && !ovf && slot_full) |=> ovf);
  // R4: each recording advances the write slot
  a_r4_wptr_moves: assert property (@(posedge clk) disable iff (!rst_n)
    rec_we |=> wptr != $past(wptr));
endmodule

// File: tb/dma_fault_ring_tb_top.sv
module dma_fault_ring_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int RB = 'h1040;

  localparam logic [63:0] T_ADDR [4] = '{64'h0000_0012_3456_7000, 64'h8000_0000_0000_1000,
                                         64'h0000_0000_DEAD_B000, 64'hFFFF_FFFF_FFFF_F000};
  localparam logic [15:0] T_RID [4] = '{16'h0108, 16'hFFFF, 16'h0000, 16'h1A2B};
  localparam logic [7:0]  T_RSN [4] = '{8'h05, 8'hFF, 8'h00, 8'h3C};
  localparam logic        T_RD  [4] = '{1'b1, 1'b0, 1'b1, 1'b0};

  logic clk = 0, rst_n = 0;
  logic flt_valid = 0, flt_is_read = 0, bus_wr = 0;
  logic [63:0] flt_addr = '0;
  logic [15:0] flt_rid = '0, bus_addr = '0;
  logic [7:0]  flt_reason = '0;
  logic [31:0] bus_wdata = '0, bus_rdata, evt_data;
  logic [63:0] evt_addr, last_addr = '0;
  logic [31:0] last_data = '0;
  logic        evt_valid;
  int tests = 0, fails = 0, evt_cnt = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_fault_ring dut_i (
    .clk(clk), .rst_n(rst_n), .flt_valid(flt_valid), .flt_addr(flt_addr),
    .flt_rid(flt_rid), .flt_reason(flt_reason), .flt_is_read(flt_is_read),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .evt_valid(evt_valid), .evt_addr(evt_addr), .evt_data(evt_data)
  );

  always @(negedge clk) if (evt_valid) begin
    evt_cnt++;
    last_data = evt_data;
    last_addr = evt_addr;
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd(int a, output logic [31:0] d);
    @(negedge clk); bus_addr = 16'(a); #1; d = bus_rdata;
  endtask

  task automatic chk_rd(string req, int a, logic [31:0] exp);
    logic [31:0] d;
    rd(a, d); check(req, d, exp);
  endtask

  task automatic set_fault(logic [63:0] a, logic [15:0] r, logic [7:0] c, logic t);
    flt_addr = a; flt_rid = r; flt_reason = c; flt_is_read = t; flt_valid = 1;
  endtask

  // optional simultaneous bus write
  task automatic step(logic fv, logic [63:0] a, logic [15:0] r, logic [7:0] c, logic t,
                      logic bw, int ba, logic [31:0] bd);
    @(negedge clk);
    if (fv) set_fault(a, r, c, t);
    bus_wr = bw; bus_addr = 16'(ba); bus_wdata = bd;
    @(negedge clk);
    flt_valid = 0; bus_wr = 0;
  endtask

  task automatic wr(int a, logic [31:0] d);
    step(0, '0, '0, '0, 0, 1, a, d);
  endtask

  task automatic fault(logic [63:0] a, logic [15:0] r, logic [7:0] c, logic t);
    step(1, a, r, c, t, 0, 0, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    chk_rd("R1 status", 'h34, 32'h0);
    chk_rd("R1 control", 'h38, 32'h8000_0000);
    chk_rd("R1 data", 'h3C, 32'h0);
    chk_rd("R1 slot0 valid", RB + 12, 32'h0);
    check("R1 no event", 32'(evt_cnt), 0);
    // R2 capability
    chk_rd("R2 cap lo", 'h08, 32'h0400_0000);
    chk_rd("R2 cap hi", 'h0C, 32'h0000_0301);
    // R12 event registers
    wr('h3C, 32'hA5A5_0001); wr('h40, 32'hFEE0_1000); wr('h44, 32'h1);
    wr('h38, 32'hC000_0000);
    chk_rd("R12 data", 'h3C, 32'hA5A5_0001);
    chk_rd("R12 addr", 'h40, 32'hFEE0_1000);
    chk_rd("R12 uaddr", 'h44, 32'h1);
    chk_rd("R12 ctrl only mask", 'h38, 32'h8000_0000);
    // R3/R4 table walk, masked
    for (int i = 0; i < 4; i++) begin
      fault(T_ADDR[i], T_RID[i], T_RSN[i], T_RD[i]);
      chk_rd("R3 R4 addr lo", RB + 16*i, T_ADDR[i][31:0]);
      chk_rd("R3 R4 addr hi", RB + 16*i + 4, T_ADDR[i][63:32]);
      chk_rd("R3 rid", RB + 16*i + 8, {16'h0, T_RID[i]});
      chk_rd("R3 type reason valid", RB + 16*i + 12, {1'b1, T_RD[i], 22'h0, T_RSN[i]});
      chk_rd("R6 pending oldest 0", 'h34, 32'h2);
    end
    chk_rd("R11 masked pending", 'h38, 32'hC000_0000);
    check("R11 no event while masked", 32'(evt_cnt), 0);
    // R7 slot 0 full
    fault(64'h1111_2222_3333_4000, 16'h0999, 8'h77, 1'b0);
    chk_rd("R7 overflow set", 'h34, 32'h3);
    chk_rd("R7 slot0 kept", RB, T_ADDR[0][31:0]);
    // R5 retire slot 0; ignored writes on slot 1
    wr(RB + 12, 32'h8000_0000);
    chk_rd("R5 slot0 cleared", RB + 12, {1'b0, T_RD[0], 22'h0, T_RSN[0]});
    chk_rd("R6 oldest moves to 1", 'h34, 32'h103);
    wr(RB + 16 + 12, 32'h0);
    wr(RB + 16, 32'hFFFF_FFFF);
    rd(RB + 16 + 12, d); check("R5 zero write no effect", {31'h0, d[31]}, 1);
    chk_rd("R5 record word read-only", RB + 16, T_ADDR[1][31:0]);
    // R8 overflow blocks, then clears
    fault(64'h0000_0000_0BAD_0000, 16'h0001, 8'h01, 1'b1);
    rd(RB + 12, d); check("R8 blocked while ovf", {31'h0, d[31]}, 0);
    wr('h34, 32'h1);
    chk_rd("R8 ovf cleared", 'h34, 32'h102);
    // R11 unmask sends pending event
    wr('h38, 32'h0);
    chk_rd("R11 ctrl after unmask", 'h38, 32'h0);
    check("R11 one event", 32'(evt_cnt), 1);
    check("R10 evt data", last_data, 32'hA5A5_0001);
    check("R10 evt addr hi", last_addr[63:32], 32'h1);
    check("R10 evt addr lo", last_addr[31:0], 32'hFEE0_1000);
    // R10 unmasked fault into slot 0
    fault(64'h55AA_0000_0000_2000, 16'h0203, 8'h11, 1'b1);
    chk_rd("R4 wrap to slot0", RB, 32'h0000_2000);
    check("R10 event per record", 32'(evt_cnt), 2);
    chk_rd("R6 oldest from wptr1", 'h34, 32'h102);
    // R9 retire slot1 and record into it in the same cycle
    step(1, 64'h0000_0066_0000_3000, 16'h0306, 8'h22, 1'b0, 1, RB + 16 + 12, 32'h8000_0000);
    chk_rd("R9 recorded lo", RB + 16, 32'h0000_3000);
    chk_rd("R9 recorded hi", RB + 20, 32'h66);
    chk_rd("R9 no overflow", 'h34, 32'h202);
    check("R10 event for R9 record", 32'(evt_cnt), 3);
    // R6 empty ring reports next write slot
    for (int i = 0; i < 4; i++) wr(RB + 16*i + 12, 32'h8000_0000);
    chk_rd("R6 empty index", 'h34, 32'h200);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule